// File: doc/BRIEF.md
# Register Status Table with Result Bypass

This block keeps the architectural register values and their rename state for an issue stage that dispatches into reservation stations. Each register holds a value, a busy flag and the tag of the reservation station that will next write it. When an instruction issues, both of its source registers are looked up. Each source comes back either as a ready value or as the tag of the station still computing it. In the same cycle, the destination register is renamed to the station tag that was allocated to the instruction.

A result bus carries finished results. Each result has a valid flag, the producer tag and a data word. A busy register whose stored tag matches the broadcast tag takes the data and becomes free. A register that was renamed again to a newer producer ignores the broadcast of the older one.

An operand looked up in the same cycle that its producer broadcasts is returned as the broadcast value, marked ready. The lookup behaves as if the write happened first in the cycle. Without this, the operand would carry a tag that disappears at the clock edge, and the consumer would wait forever. Register 0 always reads as zero and is never renamed.

Top module: `regstat_table`

## Requirements
- R1: After reset every register reads ready with value zero; the tag output reads zero whenever an operand is ready.
- R2: Register 0 always reads ready with value zero. An issue naming register 0 as destination renames nothing.
- R3: A source register that is not busy reads ready with its stored value.
- R4: An issue with `iss_valid` high and a nonzero destination makes that register read busy from the next cycle on, with `opX_ready` low and `opX_tag` equal to the issued tag.
- R5: A broadcast whose tag equals a busy register's stored tag writes the broadcast data into that register and frees it from the next cycle.
- R6: A broadcast whose tag differs from a busy register's stored tag leaves the register busy with its tag unchanged. This covers a register renamed again to a newer producer.
- R7: If a source register is busy and its stored tag is broadcast with `bc_valid` high in the lookup cycle, the operand reads ready with the broadcast data.
- R8: If an issue renames a register in the same cycle that a broadcast frees it, the register ends busy with the new tag.
- R9: A source equal to the destination of the same issue reads the state from before that issue's rename.
- R10: With `bc_valid` low, the broadcast tag and data have no effect, neither on stored state nor on same-cycle lookups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle (enables the rename) |
| iss_src_a | input | 5 | First source register number |
| iss_src_b | input | 5 | Second source register number |
| iss_dst | input | 5 | Destination register number (0 = none) |
| iss_tag | input | 4 | Reservation station tag allocated to the instruction |
| bc_valid | input | 1 | Result bus carries a result this cycle |
| bc_tag | input | 4 | Tag of the producer on the result bus |
| bc_data | input | 32 | Result value on the result bus |
| opa_ready | output | 1 | First operand is a value (1) or a pending tag (0) |
| opa_value | output | 32 | First operand value when ready, else zero |
| opa_tag | output | 4 | First operand producer tag when not ready, else zero |
| opb_ready | output | 1 | Second operand is a value (1) or a pending tag (0) |
| opb_value | output | 32 | Second operand value when ready, else zero |
| opb_tag | output | 4 | Second operand producer tag when not ready, else zero |

## Verification
The lookup is driven with free registers, registers pending on a producer, and registers whose producer broadcasts in the lookup cycle. These three patterns separate the stored-value path, the waiting path and the bypass path. Broadcasts are sent with a matching tag, with a stale tag after a second rename, and with the valid flag low. This shows that a register is freed only by its current producer. An issue and a broadcast that release the same register collide in one cycle, to confirm that the rename wins. A source naming its own destination shows that a lookup sees the state from before the rename.

// File: rtl/regstat_pkg.sv
package regstat_pkg;

   // How a looked-up operand was produced
   typedef enum logic [1:0] {
      OPS_ZERO   = 2'd0,
      OPS_FILE   = 2'd1,
      OPS_BYPASS = 2'd2,
      OPS_WAIT   = 2'd3
   } opsrc_e;

   function automatic logic opsrc_ready(opsrc_e k);
      return k != OPS_WAIT;
   endfunction

endpackage

// File: rtl/regstat_dec.sv
module regstat_dec #(
   parameter int NUM_REGS = 32,
   localparam int IDX_W = $clog2(NUM_REGS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 iss_valid,
   input  logic [IDX_W-1:0]     iss_dst,
   output logic [NUM_REGS-1:1]  ren_vec
);

   for (genvar g = 1; g < NUM_REGS; g++) begin : g_dec
      assign ren_vec[g] = iss_valid && (iss_dst == IDX_W'(g));
   end

   AST_ONE_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ren_vec)); // R4

   AST_IDLE_NO_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_valid |-> (ren_vec == '0)); // R4

endmodule

// File: rtl/regstat_entry.sv
module regstat_entry #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ren_hit,
   input  logic [TAG_W-1:0]  ren_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic              busy,
   output logic [TAG_W-1:0]  tag,
   output logic [DATA_W-1:0] value
);

   logic release_hit;

   // The broadcast frees this register only when it names the current producer
   assign release_hit = bc_valid && busy && (bc_tag == tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         tag   <= '0;
         value <= '0;
      end else begin
         if (release_hit) begin
            value <= bc_data;
            busy  <= 1'b0;
         end
         // A rename in the same cycle overrides the release
         if (ren_hit) begin
            busy <= 1'b1;
            tag  <= ren_tag;
         end
      end
   end

   AST_RENAME_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ren_hit |=> busy && (tag == $past(ren_tag))); // R8

   AST_RELEASE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && busy && (bc_tag == tag) && !ren_hit)
         |=> !busy && (value == $past(bc_data))); // R5

   AST_STALE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bc_valid && (bc_tag != tag) && !ren_hit)
         |=> busy && $stable(tag) && $stable(value)); // R6

   AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bc_valid && !ren_hit)
         |=> $stable(busy) && $stable(tag) && $stable(value)); // R10

endmodule

// File: rtl/regstat_srcsel.sv
module regstat_srcsel
   import regstat_pkg::*;
#(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 4,
   localparam int IDX_W = $clog2(NUM_REGS)
) (
   input  logic [IDX_W-1:0]  src,
   input  logic [NUM_REGS-1:0] busy_vec,
   input  logic [TAG_W-1:0]  tag_arr [NUM_REGS],
   input  logic [DATA_W-1:0] val_arr [NUM_REGS],
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output opsrc_e            kind,
   output logic              ready,
   output logic [DATA_W-1:0] value,
   output logic [TAG_W-1:0]  tag
);

   logic              sel_busy;
   logic [TAG_W-1:0]  sel_tag;
   logic [DATA_W-1:0] sel_val;
   logic              bypass_hit;

   assign sel_busy   = busy_vec[src];
   assign sel_tag    = tag_arr[src];
   assign sel_val    = val_arr[src];
   assign bypass_hit = bc_valid && (bc_tag == sel_tag);

   always_comb begin
      if (src == '0)      kind = OPS_ZERO;
      else if (!sel_busy) kind = OPS_FILE;
      else if (bypass_hit) kind = OPS_BYPASS;
      else                kind = OPS_WAIT;
   end

   always_comb begin
      ready = opsrc_ready(kind);
      value = '0;
      tag   = '0;
      unique case (kind)
         OPS_FILE:   value = sel_val;
         OPS_BYPASS: value = bc_data;
         OPS_WAIT:   tag   = sel_tag;
         default:    value = '0;
      endcase
   end

endmodule

// File: rtl/regstat_table.sv
module regstat_table
   import regstat_pkg::*;
#(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 4,
   localparam int IDX_W = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [IDX_W-1:0]  iss_src_a,
   input  logic [IDX_W-1:0]  iss_src_b,
   input  logic [IDX_W-1:0]  iss_dst,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic              opa_ready,
   output logic [DATA_W-1:0] opa_value,
   output logic [TAG_W-1:0]  opa_tag,
   output logic              opb_ready,
   output logic [DATA_W-1:0] opb_value,
   output logic [TAG_W-1:0]  opb_tag
);

   // Elaboration checks on the parameters
   if (NUM_REGS < 2 || NUM_REGS != (1 << IDX_W)) begin : g_bad_regs
      $error("NUM_REGS must be a power of two of at least 2");
   end
   if (DATA_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("DATA_W and TAG_W must be positive");
   end

   logic [NUM_REGS-1:1] ren_vec;
   logic [NUM_REGS-1:0] busy_vec;
   logic [TAG_W-1:0]    tag_arr [NUM_REGS];
   logic [DATA_W-1:0]   val_arr [NUM_REGS];
   opsrc_e              kind_a;
   opsrc_e              kind_b;

   regstat_dec #(.NUM_REGS(NUM_REGS)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_valid (iss_valid),
      .iss_dst   (iss_dst),
      .ren_vec   (ren_vec)
   );

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      if (g == 0) begin : g_hardzero
         assign busy_vec[g] = 1'b0;
         assign tag_arr[g]  = '0;
         assign val_arr[g]  = '0;
      end else begin : g_entry
         regstat_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .ren_hit  (ren_vec[g]),
            .ren_tag  (iss_tag),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_data  (bc_data),
            .busy     (busy_vec[g]),
            .tag      (tag_arr[g]),
            .value    (val_arr[g])
         );
      end
   end

   regstat_srcsel #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_sel_a (
      .src      (iss_src_a),
      .busy_vec (busy_vec),
      .tag_arr  (tag_arr),
      .val_arr  (val_arr),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .kind     (kind_a),
      .ready    (opa_ready),
      .value    (opa_value),
      .tag      (opa_tag)
   );

   regstat_srcsel #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_sel_b (
      .src      (iss_src_b),
      .busy_vec (busy_vec),
      .tag_arr  (tag_arr),
      .val_arr  (val_arr),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .kind     (kind_b),
      .ready    (opb_ready),
      .value    (opb_value),
      .tag      (opb_tag)
   );

   AST_ZERO_READS: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_src_a == '0) |-> opa_ready && (opa_value == '0)); // R2

   AST_WAIT_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      !opa_ready |-> busy_vec[iss_src_a] && !(bc_valid && (bc_tag == opa_tag))); // R7

   AST_BYPASS_B: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_b == OPS_BYPASS) |-> opb_ready && (opb_value == bc_data)); // R7

   AST_FREE_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      opb_ready |-> (opb_tag == '0)); // R1

endmodule

// File: tb/regstat_table_tb.sv
`timescale 1ns/100ps
module regstat_table_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 1'b0;
   logic [4:0]  iss_src_a = '0;
   logic [4:0]  iss_src_b = '0;
   logic [4:0]  iss_dst = '0;
   logic [3:0]  iss_tag = '0;
   logic        bc_valid = 1'b0;
   logic [3:0]  bc_tag = '0;
   logic [31:0] bc_data = '0;
   logic        opa_ready, opb_ready;
   logic [31:0] opa_value, opb_value;
   logic [3:0]  opa_tag, opb_tag;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   regstat_table u_dut (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
      .iss_dst(iss_dst), .iss_tag(iss_tag),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
      .opa_ready(opa_ready), .opa_value(opa_value), .opa_tag(opa_tag),
      .opb_ready(opb_ready), .opb_value(opb_value), .opb_tag(opb_tag)
   );

   // Drive one cycle of inputs at the falling edge; outputs settle before the rising edge
   task automatic drive(input logic iv, input int a, input int b, input int d, input int t,
                        input logic bv, input int bt, input logic [31:0] bd);
      @(negedge clk);
      iss_valid = iv; iss_src_a = 5'(a); iss_src_b = 5'(b); iss_dst = 5'(d);
      iss_tag = 4'(t); bc_valid = bv; bc_tag = 4'(bt); bc_data = bd;
      #1;
   endtask

   task automatic idle_read(input int a, input int b);
      drive(1'b0, a, b, 0, 0, 1'b0, 0, 32'h0);
   endtask

   task automatic check_op(input string req, input string side, input logic rdy,
                           input logic [31:0] val, input logic [3:0] tg, input logic er,
                           input logic [31:0] ev, input logic [3:0] et);
      n_chk++;
      if (rdy !== er || (er && (val !== ev || tg !== 4'h0)) || (!er && tg !== et)) begin
         n_bad++;
         $display("FAIL %s op%s: got ready=%0b value=%h tag=%0d, expected ready=%0b value=%h tag=%0d",
                  req, side, rdy, val, tg, er, ev, et);
      end
   endtask

   task automatic chk_a(input string req, input logic er, input logic [31:0] ev, input int et);
      check_op(req, "a", opa_ready, opa_value, opa_tag, er, ev, 4'(et));
   endtask

   task automatic chk_b(input string req, input logic er, input logic [31:0] ev, input int et);
      check_op(req, "b", opb_ready, opb_value, opb_tag, er, ev, 4'(et));
   endtask

   task automatic t_reset;
      idle_read(5, 31);
      chk_a("R1", 1'b1, 32'h0, 0);
      chk_b("R1", 1'b1, 32'h0, 0);
   endtask

   task automatic t_zero;
      drive(1'b1, 0, 0, 0, 3, 1'b0, 0, 32'h0);   // rename of r0 ignored
      drive(1'b0, 0, 1, 0, 0, 1'b1, 3, 32'h1234_5678);
      chk_a("R2", 1'b1, 32'h0, 0);
      chk_b("R2", 1'b1, 32'h0, 0);
      idle_read(0, 0);
      chk_a("R2", 1'b1, 32'h0, 0);
   endtask

   task automatic t_rename_release;
      drive(1'b1, 5, 6, 5, 2, 1'b0, 0, 32'h0);
      chk_a("R9", 1'b1, 32'h0, 0);           // own destination, pre-rename state
      idle_read(5, 6);
      chk_a("R4", 1'b0, 32'h0, 2);
      chk_b("R3", 1'b1, 32'h0, 0);
      drive(1'b0, 5, 5, 0, 0, 1'b1, 2, 32'hDEAD_BEEF);
      chk_a("R7", 1'b1, 32'hDEAD_BEEF, 0);
      chk_b("R7", 1'b1, 32'hDEAD_BEEF, 0);
      idle_read(5, 0);
      chk_a("R5", 1'b1, 32'hDEAD_BEEF, 0);
      drive(1'b1, 5, 5, 5, 11, 1'b0, 0, 32'h0);
      chk_a("R9", 1'b1, 32'hDEAD_BEEF, 0);
      idle_read(5, 0);
      chk_a("R4", 1'b0, 32'h0, 11);
      drive(1'b0, 0, 0, 0, 0, 1'b1, 11, 32'h0000_0055);
      idle_read(0, 5);
      chk_b("R3", 1'b1, 32'h0000_0055, 0);
   endtask

   task automatic t_stale;
      drive(1'b1, 0, 0, 7, 1, 1'b0, 0, 32'h0);
      drive(1'b1, 0, 0, 7, 9, 1'b0, 0, 32'h0);
      drive(1'b0, 7, 0, 0, 0, 1'b1, 1, 32'hAAAA_0001);
      chk_a("R6", 1'b0, 32'h0, 9);           // stale broadcast gives no bypass
      idle_read(7, 0);
      chk_a("R6", 1'b0, 32'h0, 9);
      drive(1'b0, 0, 0, 0, 0, 1'b1, 9, 32'hBBBB_0009);
      idle_read(7, 0);
      chk_a("R5", 1'b1, 32'hBBBB_0009, 0);
   endtask

   task automatic t_collide;
      drive(1'b1, 0, 0, 8, 4, 1'b0, 0, 32'h0);
      drive(1'b1, 0, 8, 8, 6, 1'b1, 4, 32'h0C0C_0404);
      chk_b("R7", 1'b1, 32'h0C0C_0404, 0);
      idle_read(8, 0);
      chk_a("R8", 1'b0, 32'h0, 6);
      drive(1'b0, 0, 0, 0, 0, 1'b1, 6, 32'h0606_0606);
      idle_read(0, 8);
      chk_b("R8", 1'b1, 32'h0606_0606, 0);
   endtask

   task automatic t_bc_off;
      drive(1'b1, 0, 0, 10, 5, 1'b0, 0, 32'h0);
      drive(1'b0, 10, 0, 0, 0, 1'b0, 5, 32'hFFFF_0000);
      chk_a("R10", 1'b0, 32'h0, 5);
      idle_read(10, 0);
      chk_a("R10", 1'b0, 32'h0, 5);
      drive(1'b0, 0, 0, 0, 0, 1'b1, 5, 32'h1010_1010);
      idle_read(10, 0);
      chk_a("R5", 1'b1, 32'h1010_1010, 0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_zero();
      t_rename_release();
      t_stale();
      t_collide();
      t_bc_off();
      idle_read(0, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5 * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule